// File: doc/BRIEF.md
# Flash Completion Poll Controller

This block runs on the host side of a parallel flash device. It decides whether an embedded program or erase inside the flash has finished. The command sequence that starts the embedded operation is written by other logic. Once that is done, a one-cycle `start` pulse hands this block three things: a method select, the expected data word and the address to poll. For a program, the poll address is the location that was programmed. For a sector erase, it is any address inside a sector being erased.

The block then issues status reads through a simple request/response port and keeps only one read outstanding at a time. It examines three status bits of each returned word:

- bit 7 is the data-poll bit;
- bit 6 is the toggle bit;
- bit 5 is the timeout flag.

When it reaches a verdict, it raises `done` for one cycle and presents the result on `pass`. The status bit can settle at the same moment the timeout flag rises. For that reason the block does not fail on the timeout flag alone: it always re-reads first and judges the fresh data. A poll budget ends a run that never finishes and never raises the flag. Resetting the flash after a failure is left to the surrounding logic.

Top module: `flash_done_poll`

## Requirements
- R1: While `rst` is high and in the cycle after it, `rd_req`, `done` and `busy` are 0.
- R2: A `start` seen while `busy` is 0 latches the inputs and raises `busy` and `rd_req`, with `rd_addr` equal to `poll_addr`. The latched inputs are `method` (0 = data polling, 1 = toggle checking), bit 7 of `exp_data` and `poll_addr`. A `start` seen while `busy` is 1 has no effect on the running operation.
- R3: `rd_req` stays high, with `rd_addr` held, until a cycle in which `rd_valid` is 1. `rd_valid` has no effect while `rd_req` is 0.
- R4: In data polling, a read whose bit 7 equals bit 7 of the expected data ends the operation with pass.
- R5: In data polling, a mismatching read issues a new read if its bit 5 is 0. If bit 5 is 1, the block issues exactly one more read and passes if and only if that read's bit 7 matches.
- R6: In toggle checking, reads are taken in pairs. If bit 6 is equal in both reads of a pair, the operation ends with pass.
- R7: In toggle checking, a pair whose bit 6 differs and whose second read has bit 5 equal to 0 starts a fresh pair of reads.
- R8: In toggle checking, a pair whose bit 6 differs and whose second read has bit 5 equal to 1 triggers one more pair. The result is pass if bit 6 is equal in that pair, and fail otherwise.
- R9: After MAX_POLLS polling rounds with neither completion nor bit 5 set, the operation ends with fail. A round is one read in data polling and one pair in toggle checking.
- R10: `done` is a one-cycle pulse, with `pass` valid in that cycle. It occurs two clock edges after the edge that accepted the final response. `busy` falls in the same cycle that `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin polling |
| method | input | 1 | 0 = data polling on bit 7, 1 = toggle checking on bit 6 |
| exp_data | input | DATA_W | Data last written; only bit 7 is used |
| poll_addr | input | ADDR_W | Address to read status from |
| rd_req | output | 1 | Read request, held until accepted |
| rd_addr | output | ADDR_W | Read address |
| rd_valid | input | 1 | Read response strobe |
| rd_data | input | DATA_W | Read response data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid with `done` |

## Verification
Each response accepted on an edge is registered once in the read port and acted on at the following edge. As a result, either the next `rd_req` or the `done` pulse appears two edges after the accepting edge. The bench records the cycle in which it drove the final response and requires `done` exactly two cycles later, with `busy` already low. For every run, the bench also compares the number of reads the block consumed with the count predicted by its own model of the polling rules. It injects response strobes while no request is pending, at random latencies, to show that they are dropped.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  localparam int STS_DONE_BIT = 7;
  localparam int STS_TGL_BIT  = 6;
  localparam int STS_TMO_BIT  = 5;

  typedef enum logic {
    MTH_DATA   = 1'b0,
    MTH_TOGGLE = 1'b1
  } poll_mth_t;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_DP_RD,
    PS_DP_CHK,
    PS_TG_A,
    PS_TG_B,
    PS_TG_XA,
    PS_TG_XB
  } poll_st_t;

endpackage

// File: rtl/fpoll_rd_port.sv
module fpoll_rd_port #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rsp_vld,
  output logic [DATA_W-1:0] rsp_data
);

  // single outstanding read: request held until its strobe arrives
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req  <= 1'b0;
      rsp_vld <= 1'b0;
    end else begin
      rsp_vld <= 1'b0;
      if (issue) begin
        rd_req <= 1'b1;
      end else if (rd_req && rd_valid) begin
        rd_req  <= 1'b0;
        rsp_vld <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (issue) rd_addr <= addr_in;
    if (rd_req && rd_valid) rsp_data <= rd_data;
  end

endmodule

// File: rtl/fpoll_budget.sv
module fpoll_budget #(
  parameter int MAX_POLLS = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic last
);

  localparam int CNT_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(MAX_POLLS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_V);

endmodule

// File: rtl/flash_done_poll.sv
module flash_done_poll
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  parameter int MAX_POLLS = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              method,
  input  logic [DATA_W-1:0] exp_data,
  input  logic [ADDR_W-1:0] poll_addr,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              pass
);

  poll_st_t          st, st_nxt;
  logic              exp7_q, prev6_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q, pass_q;

  logic              issue, fin, res, cap, bstep, bclr, blast;
  logic              rsp_vld;
  logic [DATA_W-1:0] rsp_data;
  logic              s_dn, s_tg, s_to, match7;
  logic [ADDR_W-1:0] iss_addr;

  assign s_dn   = rsp_data[STS_DONE_BIT];
  assign s_tg   = rsp_data[STS_TGL_BIT];
  assign s_to   = rsp_data[STS_TMO_BIT];
  assign match7 = (s_dn == exp7_q);

  assign iss_addr = (st == PS_IDLE) ? poll_addr : addr_q;

  fpoll_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk      (clk),
    .rst      (rst),
    .issue    (issue),
    .addr_in  (iss_addr),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rsp_vld  (rsp_vld),
    .rsp_data (rsp_data)
  );

  fpoll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
    .clk  (clk),
    .rst  (rst),
    .clr  (bclr),
    .step (bstep),
    .last (blast)
  );

  always_comb begin
    st_nxt = st;
    issue  = 1'b0;
    fin    = 1'b0;
    res    = 1'b0;
    cap    = 1'b0;
    bstep  = 1'b0;
    bclr   = 1'b0;
    case (st)
      PS_IDLE: begin
        if (start) begin
          bclr   = 1'b1;
          issue  = 1'b1;
          st_nxt = (poll_mth_t'(method) == MTH_TOGGLE) ? PS_TG_A : PS_DP_RD;
        end
      end
      PS_DP_RD: begin
        if (rsp_vld) begin
          if (match7) begin
            fin = 1'b1;
            res = 1'b1;
          end else if (s_to) begin
            issue  = 1'b1;
            st_nxt = PS_DP_CHK;
          end else if (blast) begin
            fin = 1'b1;
          end else begin
            bstep = 1'b1;
            issue = 1'b1;
          end
        end
      end
      PS_DP_CHK: begin
        if (rsp_vld) begin
          fin = 1'b1;
          res = match7;
        end
      end
      PS_TG_A, PS_TG_XA: begin
        if (rsp_vld) begin
          cap    = 1'b1;
          issue  = 1'b1;
          st_nxt = (st == PS_TG_A) ? PS_TG_B : PS_TG_XB;
        end
      end
      PS_TG_B: begin
        if (rsp_vld) begin
          if (s_tg == prev6_q) begin
            fin = 1'b1;
            res = 1'b1;
          end else if (s_to) begin
            issue  = 1'b1;
            st_nxt = PS_TG_XA;
          end else if (blast) begin
            fin = 1'b1;
          end else begin
            bstep  = 1'b1;
            issue  = 1'b1;
            st_nxt = PS_TG_A;
          end
        end
      end
      PS_TG_XB: begin
        if (rsp_vld) begin
          fin = 1'b1;
          res = (s_tg == prev6_q);
        end
      end
      default: st_nxt = PS_IDLE;
    endcase
    if (fin) st_nxt = PS_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= PS_IDLE;
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      st     <= st_nxt;
      done_q <= fin;
      if (fin) pass_q <= res;
    end
  end

  always_ff @(posedge clk) begin
    if (st == PS_IDLE && start) begin
      exp7_q <= exp_data[STS_DONE_BIT];
      addr_q <= poll_addr;
    end
    if (cap) prev6_q <= s_tg;
  end

  assign busy = (st != PS_IDLE);
  assign done = done_q;
  assign pass = pass_q;

endmodule

// File: rtl/fpoll_checker.sv
module fpoll_checker #(
  parameter int ADDR_W    = 24,
  parameter int MAX_POLLS = 4096
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_addr
);

  localparam int RD_MAX = 2 * MAX_POLLS + 2;

  logic [31:0] rsp_cnt;

  always_ff @(posedge clk) begin
    if (rst || (start && !busy)) rsp_cnt <= '0;
    else if (rd_req && rd_valid) rsp_cnt <= rsp_cnt + 1;
  end

  AST_RST_QUIET: assert property (@(posedge clk) rst |=> (!rd_req && !done && !busy)); // R1
  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> (busy && rd_req)); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst) (rd_req && !rd_valid) |=> rd_req); // R3
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst) (rd_req && !rd_valid) |=> $stable(rd_addr)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst) done |-> (!rd_req && !busy)); // R10
  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done); // R10
  AST_READ_BOUND: assert property (@(posedge clk) disable iff (rst) rsp_cnt <= RD_MAX); // R9

endmodule

bind flash_done_poll fpoll_checker #(.ADDR_W(ADDR_W), .MAX_POLLS(MAX_POLLS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .rd_req   (rd_req),
  .rd_valid (rd_valid),
  .rd_addr  (rd_addr)
);

// File: tb/flash_done_poll_tb.sv
module flash_done_poll_tb;

  localparam int AW   = 20;
  localparam int DW   = 16;
  localparam int MAXP = 6;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic          method;
  logic [DW-1:0] exp_data;
  logic [AW-1:0] poll_addr;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          busy, done, pass;

  int checks = 0;
  int fails  = 0;
  int ncyc   = 0;

  logic [DW-1:0] scr [64];

  flash_done_poll #(.ADDR_W(AW), .DATA_W(DW), .MAX_POLLS(MAXP)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .method    (method),
    .exp_data  (exp_data),
    .poll_addr (poll_addr),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .busy      (busy),
    .done      (done),
    .pass      (pass)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    ncyc <= ncyc + 1;
    if (ncyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic fill(input logic [DW-1:0] w);
    for (int i = 0; i < 64; i++) scr[i] = w;
  endtask

  // expected verdict and read count, from the polling rules
  task automatic ref_run(input bit m, input bit e7, output bit ps, output int nrd);
    int  i   = 0;
    int  rnd = 0;
    bit  fin = 0;
    logic [DW-1:0] a, b;
    ps = 0;
    while (!fin) begin
      if (!m) begin
        a = scr[i]; i++;
        if (a[7] == e7) begin ps = 1; fin = 1; end
        else if (a[5]) begin a = scr[i]; i++; ps = (a[7] == e7); fin = 1; end
        else if (rnd == MAXP - 1) begin ps = 0; fin = 1; end
        else rnd++;
      end else begin
        a = scr[i]; b = scr[i+1]; i += 2;
        if (a[6] == b[6]) begin ps = 1; fin = 1; end
        else if (b[5]) begin
          a = scr[i]; b = scr[i+1]; i += 2;
          ps = (a[6] == b[6]); fin = 1;
        end else if (rnd == MAXP - 1) begin ps = 0; fin = 1; end
        else rnd++;
      end
    end
    nrd = i;
  endtask

  task automatic run_op(input bit m, input logic [DW-1:0] ev, input logic [AW-1:0] a,
                        input bit inj, input bit restart, input string req);
    bit eps;
    int enrd;
    int nrd    = 0;
    int cyc    = 0;
    int t_last = -10;
    int wait_n;
    bit got    = 0;
    ref_run(m, ev[7], eps, enrd);
    @(negedge clk);
    start = 1; method = m; exp_data = ev; poll_addr = a;
    @(negedge clk);
    start = 0; method = ~m; exp_data = ~ev; poll_addr = ~a;
    wait_n = $urandom % 3;
    while (!got && cyc < 400) begin
      rd_valid = 0;
      if (done) begin
        got = 1;
        chk(pass == eps, req, "verdict", int'(pass), int'(eps));
        chk(nrd == enrd, req, "reads consumed", nrd, enrd);
        chk(cyc == t_last + 2 && !busy, "R10", "done timing", cyc - t_last, 2);
      end else if (rd_req) begin
        if (wait_n == 0) begin
          chk(rd_addr == a, "R2", "read address", int'(rd_addr), int'(a));
          rd_valid = 1;
          rd_data  = (nrd < 64) ? scr[nrd] : '0;
          nrd++;
          t_last = cyc;
          wait_n = $urandom % 3;
          if (restart && nrd == 1) start = 1;
        end else wait_n--;
      end else if (inj && ($urandom % 2 == 0)) begin
        rd_valid = 1;
        rd_data  = 16'h0020 | (ev & 16'h0080) | 16'h0040;
      end
      @(negedge clk);
      start = 0;
      cyc++;
    end
    rd_valid = 0;
    if (!got) chk(0, req, "no done", cyc, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst = 1; start = 0; method = 0; exp_data = '0; poll_addr = '0;
    rd_valid = 0; rd_data = '0;
    repeat (3) @(negedge clk);
    chk(!rd_req && !done && !busy, "R1", "reset quiet", int'({rd_req, done, busy}), 0);
    rst = 0;
    @(negedge clk);
    chk(!rd_req && !done && !busy, "R1", "after reset", int'({rd_req, done, busy}), 0);

    // R4: first read already matches
    fill(16'h0000); scr[0] = 16'h0080;
    run_op(0, 16'h00C3, 20'h1234, 0, 0, "R4");
    // R5: timeout flag then fresh match -> pass
    fill(16'h0000); scr[2] = 16'h0020; scr[3] = 16'h00A0;
    run_op(0, 16'h0080, 20'h0AAA, 0, 0, "R5");
    // R5: timeout flag, still mismatched -> fail
    fill(16'h0020);
    run_op(0, 16'h0080, 20'h0555, 0, 0, "R5");
    // R9: data polling budget with stray strobes (R3)
    fill(16'h0000);
    run_op(0, 16'h0080, 20'h7F00, 1, 0, "R9");
    // R6: no toggle in first pair
    fill(16'h0040);
    run_op(1, 16'h0000, 20'h3000, 0, 0, "R6");
    // R7: toggling without flag, then a settled pair
    fill(16'h0040); scr[0] = 16'h0000;
    run_op(1, 16'h0000, 20'h3001, 0, 0, "R7");
    // R8: flag, then settled -> pass
    fill(16'h0000); scr[1] = 16'h0060;
    run_op(1, 16'h0000, 20'h3002, 0, 0, "R8");
    // R8: flag, still toggling -> fail
    fill(16'h0000); scr[1] = 16'h0060; scr[3] = 16'h0040;
    run_op(1, 16'h0000, 20'h3003, 0, 0, "R8");
    // R9: toggle budget with stray strobes (R3)
    for (int i = 0; i < 64; i++) scr[i] = (i % 2) ? 16'h0040 : 16'h0000;
    run_op(1, 16'h0000, 20'h3004, 1, 0, "R9");
    // R2: second start while busy must not disturb the run
    fill(16'h0000); scr[3] = 16'h0080;
    run_op(0, 16'h0080, 20'h4444, 0, 1, "R2");

    for (int k = 0; k < 60; k++) begin
      for (int i = 0; i < 64; i++) begin
        scr[i] = DW'($urandom);
        scr[i][5] = ($urandom % 8 == 0);
      end
      run_op(1'($urandom), DW'($urandom), AW'($urandom), 1'($urandom), 1'($urandom),
             "R5/R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule